// File: doc/BRIEF.md
# Per-Token Symmetric Int8 Activation Quantizer

This block turns one token of fixed-point activations into signed 8-bit codes that share a single symmetric scale. Activations arrive one per cycle on an input stream. Each element is written into an on-chip token buffer, and the largest magnitude seen so far is tracked as it arrives. When the token closes, a sequential divider forms a fixed-point reciprocal of that magnitude once. The buffered elements are then replayed, each through one multiply, a rounding add and a shift, and leave as int8 codes on an output stream.

The divisor is the token's largest magnitude, raised to a small guard value `EPS` so that an all-zero token cannot divide by zero. This divisor is also presented on `scale_out`, so that downstream logic can recover an approximate activation as `code * scale_out / 127`. No zero-point and no per-channel offset exist: the mapping is symmetric about zero and is recomputed for every token. A token ends either when the `in_last` flag is accepted or when `D` elements have been accepted. While the block is dividing or replaying, it holds `in_ready` low and ignores any offered input.

Top module: `aq_token_quant`

## Requirements
- R1: After reset, and until the first token completes, `out_valid` is 0, `in_ready` is 1 and `scale_out` equals `EPS` (default 1).
- R2: Codes are two's-complement 8-bit values in [-127, +127]. The code -128 (0x80) never appears.
- R3: The element or elements whose magnitude equals the token's largest magnitude are coded as +127 or -127, following their sign.
- R4: With m = max(largest magnitude, EPS) and reciprocal Rc = floor(127·2^F / m), where F = 24 by default, each element x is coded as sign(x)·min(127, floor((|x|·Rc + 2^(F−1)) / 2^F)).
- R5: Rounding is symmetric. A value exactly halfway between two codes moves away from zero, so x and −x always receive codes of equal magnitude and opposite sign.
- R6: While a token's codes are streamed, `scale_out` equals that token's m and stays constant. It never drops below `EPS`.
- R7: A token made only of zeros yields only zero codes, and `scale_out` equals `EPS`.
- R8: A token closed by `in_last` after n ≤ D elements produces exactly n codes on consecutive cycles, in input order, with `out_last` high only on the n-th code.
- R9: From the cycle a token closes until its final code is presented, `in_ready` is 0. Inputs offered during that time are ignored and affect neither the current token nor the next one.
- R10: A token that reaches D accepted elements closes without `in_last` and is processed like any other token.
- R11: The largest magnitude includes the element that closes the token, including the most negative input value -2^(DW−1), whose magnitude 2^(DW−1) is used in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block accepts input elements |
| in_data | input | DW | Signed fixed-point activation |
| in_last | input | 1 | Marks the final element of a token |
| out_valid | output | 1 | Output code valid |
| out_data | output | 8 | Signed int8 code |
| out_last | output | 1 | Marks the final code of a token |
| scale_out | output | DW+1 | Token divisor m = max(largest magnitude, EPS) |

## Verification
The token's final element is written into the buffer and folded into the running maximum in the same cycle that closes the token and schedules the divider start. The divider must therefore use a maximum that already includes that element. Tokens whose largest magnitude, including -32768, sits in the last position provoke this case. The result is judged by whether `scale_out` equals that magnitude and whether the element's code is exactly ±127. A second overlap, the final code appearing in the same cycle that `in_ready` reopens, is provoked by holding input valid throughout processing and is judged by whether the next token remains uncorrupted.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } aq_state_e;

  localparam int QMAX = 127;
endpackage

// File: rtl/aq_absmax.sv
module aq_absmax #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [DW-1:0] din,
  output logic [DW:0]   amax
);
  localparam int AW = DW + 1;

  logic signed [AW-1:0] sx;
  logic [AW-1:0] mag;
  logic [AW-1:0] amax_q, amax_n;

  always_comb begin
    sx  = {din[DW-1], din};
    mag = sx[AW-1] ? AW'(-sx) : AW'(sx);
    amax_n = amax_q;
    if (en) begin
      if (first || (mag > amax_q)) amax_n = mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amax_q <= '0;
    else        amax_q <= amax_n;
  end

  assign amax = amax_q;
endmodule

// File: rtl/aq_recip_div.sv
module aq_recip_div #(
  parameter int AW = 17,
  parameter int F  = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   divisor,
  output logic            done,
  output logic [F+6:0]    quot
);
  localparam int NW = F + 7;
  localparam int CW = $clog2(NW + 1);
  localparam logic [NW-1:0] DVD = {7'd127, {F{1'b0}}};

  logic          run_q, run_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] rem_q, rem_n;
  logic [AW-1:0] div_q, div_n;
  logic [NW-1:0] quo_q, quo_n;
  logic [NW-1:0] num_q, num_n;
  logic [AW:0]   trial, diff;
  logic          fits;

  always_comb begin
    trial  = {rem_q, num_q[NW-1]};
    diff   = trial - {1'b0, div_q};
    fits   = (trial >= {1'b0, div_q});
    run_n  = run_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    div_n  = div_q;
    quo_n  = quo_q;
    num_n  = num_q;
    if (start) begin
      run_n = 1'b1;
      cnt_n = CW'(NW);
      rem_n = '0;
      quo_n = '0;
      div_n = divisor;
      num_n = DVD;
    end else if (run_q) begin
      rem_n = fits ? diff[AW-1:0] : trial[AW-1:0];
      quo_n = {quo_q[NW-2:0], fits};
      num_n = {num_q[NW-2:0], 1'b0};
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
    end else begin
      run_q  <= run_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      div_q  <= div_n;
      quo_q  <= quo_n;
      num_q  <= num_n;
    end
  end

  assign done = done_q;
  assign quot = quo_q;
endmodule

// File: rtl/aq_scale_mult.sv
module aq_scale_mult #(
  parameter int DW = 16,
  parameter int F  = 24
) (
  input  logic [DW-1:0]  din,
  input  logic [F+6:0]   recip,
  output logic [7:0]     q
);
  import aq_pkg::*;
  localparam int AW = DW + 1;
  localparam int NW = F + 7;
  localparam int PW = AW + NW;
  localparam logic [PW-1:0] HALF = PW'(1) << (F - 1);

  logic signed [AW-1:0] sx;
  logic [AW-1:0] mag;
  logic [PW-1:0] prod, rnd;
  logic [6:0]    clip;

  always_comb begin
    sx   = {din[DW-1], din};
    mag  = sx[AW-1] ? AW'(-sx) : AW'(sx);
    prod = PW'(mag) * PW'(recip);
    rnd  = (prod + HALF) >> F;
    clip = (rnd > PW'(QMAX)) ? 7'(QMAX) : rnd[6:0];
    q    = din[DW-1] ? 8'(-{1'b0, clip}) : {1'b0, clip};
  end
endmodule

// File: rtl/aq_token_quant.sv
module aq_token_quant #(
  parameter int DW  = 16,
  parameter int D   = 16,
  parameter int F   = 24,
  parameter int EPS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [DW:0]   scale_out
);
  import aq_pkg::*;
  localparam int AW = DW + 1;
  localparam int NW = F + 7;
  localparam int IW = (D > 1) ? $clog2(D) : 1;

  aq_state_e     state_q, state_n;
  logic [IW-1:0] wr_idx_q, wr_idx_n;
  logic [IW-1:0] rd_idx_q, rd_idx_n;
  logic [IW-1:0] len_q, len_n;
  logic          start_q, start_n;
  logic [NW-1:0] recip_q, recip_n;
  logic [AW-1:0] scale_q, scale_n;
  logic          ov_q, ov_n;
  logic          ol_q, ol_n;
  logic [7:0]    od_q, od_n;

  logic [DW-1:0] tok_mem [D];
  logic          accept, tok_end, div_done;
  logic [AW-1:0] amax, guard_m;
  logic [NW-1:0] div_quot;
  logic [7:0]    code;

  assign accept   = in_valid && (state_q == ST_FILL);
  assign tok_end  = accept && (in_last || (wr_idx_q == IW'(D - 1)));
  assign guard_m  = (amax < AW'(EPS)) ? AW'(EPS) : amax;

  always_ff @(posedge clk) begin
    if (accept) tok_mem[wr_idx_q] <= in_data;
  end

  aq_absmax #(.DW(DW)) u_amax (
    .clk(clk), .rst_n(rst_n), .en(accept),
    .first(wr_idx_q == '0), .din(in_data), .amax(amax)
  );

  aq_recip_div #(.AW(AW), .F(F)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_q),
    .divisor(guard_m), .done(div_done), .quot(div_quot)
  );

  aq_scale_mult #(.DW(DW), .F(F)) u_mult (
    .din(tok_mem[rd_idx_q]), .recip(recip_q), .q(code)
  );

  always_comb begin
    state_n  = state_q;
    wr_idx_n = wr_idx_q;
    rd_idx_n = rd_idx_q;
    len_n    = len_q;
    start_n  = 1'b0;
    recip_n  = recip_q;
    scale_n  = scale_q;
    ov_n     = 1'b0;
    ol_n     = 1'b0;
    od_n     = od_q;
    unique case (state_q)
      ST_FILL: begin
        if (accept) begin
          wr_idx_n = wr_idx_q + IW'(1);
          if (tok_end) begin
            state_n  = ST_DIV;
            start_n  = 1'b1;
            len_n    = wr_idx_q;
            wr_idx_n = '0;
          end
        end
      end
      ST_DIV: begin
        if (div_done) begin
          state_n  = ST_OUT;
          recip_n  = div_quot;
          scale_n  = guard_m;
          rd_idx_n = '0;
        end
      end
      ST_OUT: begin
        ov_n     = 1'b1;
        od_n     = code;
        ol_n     = (rd_idx_q == len_q);
        rd_idx_n = rd_idx_q + IW'(1);
        if (rd_idx_q == len_q) begin
          state_n  = ST_FILL;
          rd_idx_n = '0;
        end
      end
      default: state_n = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_FILL;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      len_q    <= '0;
      start_q  <= 1'b0;
      recip_q  <= '0;
      scale_q  <= AW'(EPS);
      ov_q     <= 1'b0;
      ol_q     <= 1'b0;
      od_q     <= '0;
    end else begin
      state_q  <= state_n;
      wr_idx_q <= wr_idx_n;
      rd_idx_q <= rd_idx_n;
      len_q    <= len_n;
      start_q  <= start_n;
      recip_q  <= recip_n;
      scale_q  <= scale_n;
      ov_q     <= ov_n;
      ol_q     <= ol_n;
      od_q     <= od_n;
    end
  end

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_data  = od_q;
  assign scale_out = scale_q;
endmodule

// File: rtl/aq_token_quant_chk.sv
module aq_token_quant_chk #(
  parameter int DW  = 16,
  parameter int EPS = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic [DW:0] scale_out
);
  // R2: the code 0x80 must never be emitted
  a_r2_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data != 8'h80));

  // R6: the divisor never goes below the guard value
  a_r6_scale_floor: assert property (@(posedge clk) disable iff (!rst_n)
    scale_out >= (DW+1)'(EPS));

  // R6: the scale holds while a token's codes stream out
  a_r6_scale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(scale_out));

  // R9: input stays closed while codes other than the last are emitted
  a_r9_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);

  // R8: codes of one token are contiguous
  a_r8_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R8: the final code is followed by a gap
  a_r8_last_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);
endmodule

bind aq_token_quant aq_token_quant_chk #(.DW(DW), .EPS(EPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .scale_out(scale_out)
);

// File: tb/aq_token_quant_tb.sv
`timescale 1ns/1ps
module aq_token_quant_tb;
  localparam int DW = 16;
  localparam int D  = 8;
  localparam int F  = 24;
  localparam int NT = 4;

  // four tokens of D elements; tokens 1 and 3 are closed by in_last
  localparam int TV [NT*D] = '{
    100, -50, 25, 0, 3, -1, 7, -100,
    -32768, 32767, 1, -1, 16384, -16384, 255, 0,
    1, -1, 3, -3, 5, -5, 254, -253,
    1, 2, 3, 4, 5, 6, 7, 1000
  };

  logic clk, rst_n;
  logic in_valid, in_ready, in_last;
  logic [DW-1:0] in_data;
  logic out_valid, out_last;
  logic [7:0] out_data;
  logic [DW:0] scale_out;

  int n_run, n_fail;
  int tok [D];
  bit junk;

  aq_token_quant #(.DW(DW), .D(D), .F(F), .EPS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .scale_out(scale_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int x, input int m);
    longint r, ax, v;
    r  = (longint'(127) <<< F) / m;
    ax = (x < 0) ? -x : x;
    v  = (ax * r + (longint'(1) <<< (F - 1))) >>> F;
    if (v > 127) v = 127;
    return (x < 0) ? int'(-v) : int'(v);
  endfunction

  // drive n elements of tok[], then collect and judge n codes
  task automatic run_token(input int n, input bit use_last, input string req);
    int m;
    m = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      a = (tok[i] < 0) ? -tok[i] : tok[i];
      if (a > m) m = a;
    end
    if (m < 1) m = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(tok[i]);
      in_last  = use_last && (i == n - 1);
    end
    @(negedge clk);
    in_valid = junk;            // R9: junk offered while busy
    in_data  = 16'sd32767;
    in_last  = 1'b1;
    for (int k = 0; k < n; k++) begin
      int wd;
      wd = 0;
      while (!out_valid && wd < 400) begin
        @(negedge clk);
        wd++;
      end
      if (wd >= 400) begin
        chk(1'b0, "watchdog", 0, 1);
        in_valid = 1'b0;
        return;
      end
      chk($signed(out_data) == exp_code(tok[k], m), req,
          $signed(out_data), exp_code(tok[k], m));
      chk(out_last == (k == n - 1), "R8 last flag", out_last, (k == n - 1));
      chk(scale_out == (DW+1)'(m), "R6 scale", scale_out, m);
      if (k == n - 1) begin
        in_valid = 1'b0;
        chk(in_ready == 1'b1, "R9 reopen", in_ready, 1);
      end else begin
        chk(in_ready == 1'b0, "R9 busy", in_ready, 0);
        @(negedge clk);
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 gap after last", out_valid, 0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; junk = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(scale_out == 17'd1, "R1 scale", scale_out, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle", out_valid, 0);

    // table walk: R4 R3 R5 R10 R11 across several patterns
    for (int t = 0; t < NT; t++) begin
      for (int i = 0; i < D; i++) tok[i] = TV[t*D + i];
      run_token(D, t[0], "R4 code");
    end

    // R3 and R11: largest magnitude as closing element, negative extreme
    tok[0] = 5; tok[1] = -300; tok[2] = -32768;
    run_token(3, 1'b1, "R11 closing max");

    // R5: halfway values round away from zero, symmetric
    tok[0] = 2; tok[1] = -2; tok[2] = 6; tok[3] = -6; tok[4] = 508;
    run_token(5, 1'b1, "R5 half away");

    // R7: all-zero token
    for (int i = 0; i < D; i++) tok[i] = 0;
    run_token(D, 1'b1, "R7 zero token");

    // R9: junk held valid while busy must not disturb this or next token
    junk = 1'b1;
    tok[0] = 10; tok[1] = -20; tok[2] = 5;
    run_token(3, 1'b1, "R9 junk ignored");
    junk = 1'b0;
    tok[0] = 40; tok[1] = -7;
    run_token(2, 1'b1, "R9 next token");

    // R8: single-element token
    tok[0] = -9;
    run_token(1, 1'b1, "R8 single");

    // R1: reset in the middle of a token
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'd77; in_last = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(scale_out == 17'd1, "R1 scale after reset", scale_out, 1);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    rst_n = 1'b1;
    tok[0] = 3; tok[1] = -12;
    run_token(2, 1'b1, "R1 token after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule